// File: doc/BRIEF.md
# Restartable Pointer Address Generator

This block produces operand addresses for a processor whose small pointer register file supports three addressing modes: plain register-indirect, post-increment and pre-decrement. Each operand request names a register, a mode and an operand size. The effective address comes back in the same cycle, and the pointer side effect is written on the next clock edge.

An instruction can change one pointer several times, or change two pointers: a post-incremented source and a pre-decremented destination. Those changes stay speculative until the instruction commits. Each register keeps a shadow copy of its value from before the first change in the current instruction, plus a dirty flag. A fault pulse at any operand access, including the final store, copies every dirty shadow back in one cycle. This returns the register file to its state at instruction start, so the instruction can be issued again. A separate load port writes results into the registers. Reads go through a combinational read port.

Top module: `ptr_rollback_agu`

## Requirements
- R1: Mode code 0 (indirect) and the reserved code 3 return the selected register as the address and leave that register unchanged.
- R2: Mode code 1 (post-increment) returns the register's current value as the address. On the next edge it writes that value plus the step.
- R3: Mode code 2 (pre-decrement) returns the register value minus the step as the address. On the next edge it writes that same decremented value into the register.
- R4: The step is 1 when `req_word` is 0 (byte) and 2 when it is 1 (word). Arithmetic wraps modulo 2^16.
- R5: A fault pulse restores every register changed since the instruction began to its value at instruction start. This holds when two different registers were changed. The restored values are readable right after the fault edge.
- R6: If one register is changed more than once in an instruction, a fault restores the value it had before its first change.
- R7: A commit pulse keeps the updated values and drops all shadows. A fault that follows with no new changes alters no register.
- R8: An `instr_start` pulse clears all dirty flags, so changes made before it are not undone by a later fault.
- R9: A fault takes priority over everything else in the same cycle. That cycle's pointer update and load are dropped, while dirty registers are still restored. The address output still reflects the request.
- R10: `wr_en` loads `wr_data` into register `wr_idx`. A load is not tracked, so a fault does not undo it. If a pointer update targets the same register in the same cycle, the update wins.
- R11: After reset every register reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_start | input | 1 | Marks the first cycle of a new instruction; clears dirty flags |
| commit | input | 1 | Instruction completed; side effects become permanent |
| fault | input | 1 | Memory fault; roll back dirty registers |
| req_valid | input | 1 | Operand address request |
| req_idx | input | 3 | Pointer register index |
| req_mode | input | 2 | 0 indirect, 1 post-increment, 2 pre-decrement, 3 indirect |
| req_word | input | 1 | 1 word operand (step 2), 0 byte operand (step 1) |
| req_addr | output | 16 | Effective operand address, combinational |
| wr_en | input | 1 | Register load enable |
| wr_idx | input | 3 | Register load index |
| wr_data | input | 16 | Register load value |
| rd_idx | input | 3 | Read port index |
| rd_data | output | 16 | Read port value, combinational |

## Verification
A wrong internal value shows up in one of two places: on `req_addr` in the same cycle for any request that uses that register, or on `rd_data` one edge after the update. A lost or stale shadow stays hidden until a fault. After the fault the read port shows a restored value that differs from the instruction-start value. For this reason the bench reads back the whole register file after every committed or faulted instruction. A dirty flag that is set or cleared wrongly shows up the same way, when a later fault restores too much or too little.

// File: rtl/agu_pkg.sv
`timescale 1ns/1ps
package agu_pkg;

    typedef enum logic [1:0] {
        AM_INDIRECT = 2'd0,
        AM_POSTINC  = 2'd1,
        AM_PREDEC   = 2'd2,
        AM_RESERVED = 2'd3
    } amode_e;

endpackage

// File: rtl/agu_step_calc.sv
`timescale 1ns/1ps
module agu_step_calc
    import agu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] base_i,
    input  logic [1:0]        mode_i,
    input  logic              word_i,
    output logic [DATA_W-1:0] addr_o,
    output logic [DATA_W-1:0] next_o,
    output logic              modifies_o
);
    logic [DATA_W-1:0] step;

    always_comb begin
        step       = word_i ? DATA_W'(2) : DATA_W'(1);
        addr_o     = base_i;
        next_o     = base_i;
        modifies_o = 1'b0;
        case (amode_e'(mode_i))
            AM_POSTINC: begin
                addr_o     = base_i;
                next_o     = base_i + step;
                modifies_o = 1'b1;
            end
            AM_PREDEC: begin
                addr_o     = base_i - step;
                next_o     = base_i - step;
                modifies_o = 1'b1;
            end
            default: begin
                addr_o     = base_i;
                next_o     = base_i;
                modifies_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/agu_sel_decode.sv
`timescale 1ns/1ps
module agu_sel_decode #(
    parameter int NUM_REGS = 8,
    localparam int IDX_W = $clog2(NUM_REGS)
) (
    input  logic             upd_en_i,
    input  logic [IDX_W-1:0] upd_idx_i,
    input  logic             ld_en_i,
    input  logic [IDX_W-1:0] ld_idx_i,
    output logic [NUM_REGS-1:0] upd_sel_o,
    output logic [NUM_REGS-1:0] ld_sel_o
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
        assign upd_sel_o[g] = upd_en_i && (upd_idx_i == IDX_W'(g));
        assign ld_sel_o[g]  = ld_en_i  && (ld_idx_i  == IDX_W'(g));
    end
endmodule

// File: rtl/agu_reg_slot.sv
`timescale 1ns/1ps
module agu_reg_slot #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              commit_i,
    input  logic              fault_i,
    input  logic              upd_i,
    input  logic [DATA_W-1:0] upd_val_i,
    input  logic              ld_i,
    input  logic [DATA_W-1:0] ld_val_i,
    output logic [DATA_W-1:0] val_o,
    output logic              dirty_o
);
    typedef struct packed {
        logic [DATA_W-1:0] val;
        logic [DATA_W-1:0] shadow;
        logic              dirty;
    } slot_t;

    slot_t slot_d, slot_q;
    logic  dirty_live;

    always_comb begin
        slot_d     = slot_q;
        dirty_live = slot_q.dirty && !start_i;
        if (fault_i) begin
            if (slot_q.dirty) begin
                slot_d.val = slot_q.shadow;
            end
            slot_d.dirty = 1'b0;
        end else begin
            slot_d.dirty = dirty_live;
            if (upd_i) begin
                if (!dirty_live) begin
                    slot_d.shadow = slot_q.val;
                end
                slot_d.dirty = 1'b1;
                slot_d.val   = upd_val_i;
            end else if (ld_i) begin
                slot_d.val = ld_val_i;
            end
            if (commit_i) begin
                slot_d.dirty = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign val_o   = slot_q.val;
    assign dirty_o = slot_q.dirty;
endmodule

// File: rtl/ptr_rollback_agu.sv
`timescale 1ns/1ps
module ptr_rollback_agu #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 16,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_start,
    input  logic              commit,
    input  logic              fault,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [1:0]        req_mode,
    input  logic              req_word,
    output logic [DATA_W-1:0] req_addr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
    logic [NUM_REGS-1:0]             dirty_q;
    logic [NUM_REGS-1:0]             upd_sel;
    logic [NUM_REGS-1:0]             ld_sel;
    logic [DATA_W-1:0]               base_val;
    logic [DATA_W-1:0]               next_val;
    logic                            modifies;

    assign base_val = regs_q[req_idx];

    agu_step_calc #(.DATA_W(DATA_W)) u_calc (
        .base_i     (base_val),
        .mode_i     (req_mode),
        .word_i     (req_word),
        .addr_o     (req_addr),
        .next_o     (next_val),
        .modifies_o (modifies)
    );

    agu_sel_decode #(.NUM_REGS(NUM_REGS)) u_dec (
        .upd_en_i  (req_valid && modifies),
        .upd_idx_i (req_idx),
        .ld_en_i   (wr_en),
        .ld_idx_i  (wr_idx),
        .upd_sel_o (upd_sel),
        .ld_sel_o  (ld_sel)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        agu_reg_slot #(.DATA_W(DATA_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .start_i   (instr_start),
            .commit_i  (commit),
            .fault_i   (fault),
            .upd_i     (upd_sel[g]),
            .upd_val_i (next_val),
            .ld_i      (ld_sel[g]),
            .ld_val_i  (wr_data),
            .val_o     (regs_q[g]),
            .dirty_o   (dirty_q[g])
        );
    end

    assign rd_data = regs_q[rd_idx];
endmodule

// File: rtl/agu_rollback_chk.sv
`timescale 1ns/1ps
module agu_rollback_chk #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 16,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            commit,
    input logic                            fault,
    input logic                            req_valid,
    input logic [IDX_W-1:0]                req_idx,
    input logic [1:0]                      req_mode,
    input logic                            req_word,
    input logic [DATA_W-1:0]               req_addr,
    input logic                            wr_en,
    input logic [NUM_REGS-1:0][DATA_W-1:0] regs_q,
    input logic [NUM_REGS-1:0]             dirty_q
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
    localparam logic [DATA_W-1:0] TWO = DATA_W'(2);

    AST_IND_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_mode == 2'd0 || req_mode == 2'd3)) |-> (req_addr == regs_q[req_idx])); // R1

    AST_POSTINC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !fault && req_mode == 2'd1) |=>
        (regs_q[$past(req_idx)] == $past(req_addr) + ($past(req_word) ? TWO : ONE))); // R2

    AST_PREDEC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !fault && req_mode == 2'd2) |=> (regs_q[$past(req_idx)] == $past(req_addr))); // R3

    AST_PREDEC_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'd2) |-> (req_addr + (req_word ? TWO : ONE) == regs_q[req_idx])); // R4

    AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (dirty_q == '0)); // R5

    AST_COMMIT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !fault) |=> (dirty_q == '0)); // R7

    AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !wr_en && !fault) |=> $stable(regs_q)); // R10
endmodule

bind ptr_rollback_agu agu_rollback_chk #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit),
    .fault     (fault),
    .req_valid (req_valid),
    .req_idx   (req_idx),
    .req_mode  (req_mode),
    .req_word  (req_word),
    .req_addr  (req_addr),
    .wr_en     (wr_en),
    .regs_q    (regs_q),
    .dirty_q   (dirty_q)
);

// File: tb/tb_ptr_rollback_agu.sv
`timescale 1ns/1ps
module tb_ptr_rollback_agu;
    localparam int N = 8;
    localparam int W = 16;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic         rst_n = 1'b0;
    logic         instr_start = 0, commit = 0, fault = 0, req_valid = 0, req_word = 0, wr_en = 0;
    logic [2:0]   req_idx = 0, wr_idx = 0, rd_idx = 0;
    logic [1:0]   req_mode = 0;
    logic [W-1:0] wr_data = 0;
    logic [W-1:0] req_addr, rd_data;

    ptr_rollback_agu dut (
        .clk(clk), .rst_n(rst_n), .instr_start(instr_start), .commit(commit), .fault(fault),
        .req_valid(req_valid), .req_idx(req_idx), .req_mode(req_mode), .req_word(req_word),
        .req_addr(req_addr), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    int checks = 0;
    int errors = 0;
    logic [W-1:0] m_val [N];
    logic [W-1:0] m_sh  [N];
    logic         m_dirty [N];

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] step_of(input logic wd);
        return wd ? W'(2) : W'(1);
    endfunction

    function automatic logic [W-1:0] exp_addr(input logic [1:0] md, input logic wd, input logic [W-1:0] b);
        return (md == 2'd2) ? b - step_of(wd) : b;
    endfunction

    function automatic logic [W-1:0] exp_next(input logic [1:0] md, input logic wd, input logic [W-1:0] b);
        if (md == 2'd1) return b + step_of(wd);
        if (md == 2'd2) return b - step_of(wd);
        return b;
    endfunction

    task automatic check_regs(input string req);
        for (int i = 0; i < N; i++) begin
            rd_idx = 3'(i);
            #0.1;
            chk($sformatf("%s reg%0d", req, i), rd_data, m_val[i]);
        end
    endtask

    task automatic op(input logic st, input logic cm, input logic ft,
                      input logic rv, input logic [2:0] ix, input logic [1:0] md, input logic wd,
                      input logic we, input logic [2:0] wi, input logic [W-1:0] wdv,
                      input string req);
        logic upd;
        @(negedge clk);
        instr_start = st; commit = cm; fault = ft;
        req_valid = rv; req_idx = ix; req_mode = md; req_word = wd;
        wr_en = we; wr_idx = wi; wr_data = wdv;
        #0.5;
        if (rv) chk({req, " addr"}, req_addr, exp_addr(md, wd, m_val[ix]));
        @(posedge clk);
        upd = rv && (md == 2'd1 || md == 2'd2);
        if (ft) begin
            for (int i = 0; i < N; i++) begin
                if (m_dirty[i]) m_val[i] = m_sh[i];
                m_dirty[i] = 1'b0;
            end
        end else begin
            if (st) for (int i = 0; i < N; i++) m_dirty[i] = 1'b0;
            if (we && !(upd && wi == ix)) m_val[wi] = wdv;
            if (upd) begin
                if (!m_dirty[ix]) m_sh[ix] = m_val[ix];
                m_dirty[ix] = 1'b1;
                m_val[ix] = exp_next(md, wd, m_val[ix]);
            end
            if (cm) for (int i = 0; i < N; i++) m_dirty[i] = 1'b0;
        end
        #0.5;
        instr_start = 0; commit = 0; fault = 0; req_valid = 0; wr_en = 0;
    endtask

    task automatic load(input logic [2:0] wi, input logic [W-1:0] v, input string req);
        op(0, 0, 0, 0, 3'd0, 2'd0, 0, 1, wi, v, req);
    endtask

    task automatic req1(input logic st, input logic [2:0] ix, input logic [1:0] md, input logic wd, input string req);
        op(st, 0, 0, 1, ix, md, wd, 0, 3'd0, '0, req);
    endtask

    task automatic fault_only(input string req);
        op(0, 0, 1, 0, 3'd0, 2'd0, 0, 0, 3'd0, '0, req);
    endtask

    task automatic commit_only(input string req);
        op(0, 1, 0, 0, 3'd0, 2'd0, 0, 0, 3'd0, '0, req);
    endtask

    initial begin
        #(200000 * 5.0);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0A61));
        for (int i = 0; i < N; i++) begin
            m_val[i] = '0; m_sh[i] = '0; m_dirty[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check_regs("R11 reset");

        // R10 loads
        load(3'd2, 16'h1000, "R10");
        load(3'd3, 16'h2000, "R10");
        check_regs("R10 load");

        // R2 / R3 / R5: move with post-inc source and pre-dec destination, fault on store
        req1(1, 3'd2, 2'd1, 1, "R2 postinc");
        req1(0, 3'd3, 2'd2, 1, "R3 predec");
        check_regs("R2 R3 after update");
        fault_only("R5");
        check_regs("R5 rollback");

        // R7: same instruction committed, then a bare fault changes nothing
        req1(1, 3'd2, 2'd1, 1, "R2 postinc");
        req1(0, 3'd3, 2'd2, 1, "R3 predec");
        commit_only("R7");
        fault_only("R7");
        check_regs("R7 commit");

        // R6: same register changed twice
        load(3'd4, 16'h0050, "R10");
        req1(1, 3'd4, 2'd1, 1, "R6 first");
        req1(0, 3'd4, 2'd1, 1, "R6 second");
        req1(0, 3'd4, 2'd2, 0, "R6 third");
        fault_only("R6");
        check_regs("R6 rollback");

        // R4: byte step and wrap-around
        load(3'd5, 16'h0000, "R10");
        load(3'd6, 16'hFFFF, "R10");
        req1(1, 3'd5, 2'd2, 1, "R4 wrap predec");
        req1(0, 3'd6, 2'd1, 0, "R4 wrap postinc byte");
        req1(0, 3'd6, 2'd2, 0, "R4 predec byte");
        commit_only("R4");
        check_regs("R4 steps");

        // R1: indirect codes 0 and 3
        req1(1, 3'd2, 2'd0, 1, "R1 mode0");
        req1(0, 3'd3, 2'd3, 0, "R1 mode3");
        commit_only("R1");
        check_regs("R1 unchanged");

        // R8: instr_start clears dirty flags
        req1(1, 3'd1, 2'd1, 1, "R8 first instr");
        req1(1, 3'd0, 2'd1, 1, "R8 second instr");
        fault_only("R8");
        check_regs("R8 start clears");

        // R9: fault in the same cycle as a request and a load
        load(3'd7, 16'h7777, "R10");
        req1(1, 3'd2, 2'd1, 1, "R9 pre");
        op(0, 0, 1, 1, 3'd3, 2'd1, 1, 1, 3'd7, 16'hDEAD, "R9 fault+req");
        check_regs("R9 priority");

        // R10: update beats load to the same register; loads are not undone
        op(1, 0, 0, 1, 3'd1, 2'd1, 1, 1, 3'd1, 16'hAAAA, "R10 collide");
        commit_only("R10");
        op(1, 0, 0, 0, 3'd0, 2'd0, 0, 1, 3'd6, 16'h1234, "R10 load in instr");
        fault_only("R10");
        check_regs("R10 collision and untracked");

        // random instructions
        for (int n = 0; n < 250; n++) begin
            int k;
            k = 1 + int'($urandom_range(0, 2));
            for (int j = 0; j < k; j++) begin
                logic we;
                we = ($urandom_range(0, 5) == 0);
                op(j == 0, 0, 0, 1, 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
                   1'($urandom_range(0, 1)), we, 3'($urandom_range(0, 7)), 16'($urandom),
                   "R2 R3 random");
            end
            case ($urandom_range(0, 2))
                0: commit_only("R7 random");
                1: fault_only("R5 random");
                default: op(0, 0, 1, 1, 3'($urandom_range(0, 7)), 2'($urandom_range(1, 2)),
                            1'($urandom_range(0, 1)), 1, 3'($urandom_range(0, 7)), 16'($urandom),
                            "R9 random");
            endcase
            check_regs("R5 random state");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule